// File: doc/BRIEF.md
# IR Key-Repeat Detector with Output Code Hold

This block sits behind an infrared frame decoder. It receives each fully decoded data word with a one-cycle valid strobe and decides whether the word is a fresh key press or a repeat of a held key. It recognises a repeat by comparing the word with the previous one and by timing the gap between them. The time base is a free-running prescaler that produces a 10 us tick and a 100 us tick. A mode input picks which of the two ticks drives a saturating frame-to-frame interval counter.

Fresh presses go to an output code register and raise a new-code flag. Software clears that flag with a read strobe. When code hold is enabled, the register keeps its contents while the flag is set, so an unread code is never overwritten. Repeats do not touch the register. Instead they raise a one-cycle repeat pulse.

There are two state machines. The reference machine has the states `REF_NONE` and `REF_VALID`. It makes the transition `REF_NONE -> REF_VALID` on the first frame after reset, and every later frame keeps it in `REF_VALID` (`REF_VALID -> REF_VALID`). The output machine has the states `OUT_READ` and `OUT_PENDING`. It moves `OUT_READ -> OUT_PENDING` on a store, `OUT_PENDING -> OUT_READ` on a read strobe with no store in the same cycle, and `OUT_PENDING -> OUT_PENDING` on a store.

Top module: `ir_repeat_det`

## Requirements
- R1: After reset, `code_out` is 0, and `new_code` and `repeat_flag` are 0.
- R2: While `cnt_en` is 1, the interval counter advances by one on every 10 us tick when `tick_fine` is 1, and on every 100 us tick when `tick_fine` is 0. A 10 us tick lasts `CYC_PER_10US` clocks. A frame strobe restarts the counter at 0.
- R3: A frame is a repeat exactly when all of these hold: `cmp_en` is 1, a reference frame exists, `frame_code` equals the reference, and either `time_chk_en` is 0 or (`cnt_en` is 1 and the interval count is strictly below `gap_max`). Every other frame is a new press.
- R4: The first frame after reset is always a new press, even if its code is 0.
- R5: The interval counter saturates at its all-ones value and does not wrap. A long pause therefore never produces a repeat when the time check is on.
- R6: While `cnt_en` is 0, the counter stays at 0. With `time_chk_en` at 1, no frame is then a repeat.
- R7: Every new-press frame becomes the reference, even when code hold stops it from being stored.
- R8: `repeat_flag` is high for exactly the one cycle after the clock edge that takes a repeat frame. A repeat changes neither `code_out` nor `new_code`.
- R9: A new press is written to `code_out` when `hold_en` is 0 or `new_code` is 0. The write sets `new_code`, and both are visible one cycle after the frame strobe.
- R10: With `hold_en` at 1 and `new_code` at 1, `code_out` keeps its value and new presses are not stored.
- R11: `rd_strobe` clears `new_code` one cycle later. If a store happens in the same cycle, the store wins and `new_code` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle strobe: `frame_code` holds a decoded frame |
| frame_code | input | CODE_W | Decoded data word |
| cnt_en | input | 1 | Enables the frame-to-frame interval counter |
| time_chk_en | input | 1 | Applies the interval limit to repeat detection |
| cmp_en | input | 1 | Enables frame comparison for repeat detection |
| tick_fine | input | 1 | 1: count 10 us ticks, 0: count 100 us ticks |
| gap_max | input | GAP_W | Interval limit in ticks; a repeat needs count < limit |
| hold_en | input | 1 | Freezes `code_out` until it has been read |
| rd_strobe | input | 1 | Software read of the output code |
| code_out | output | CODE_W | Stored code of the last accepted key press |
| new_code | output | 1 | Unread code present in `code_out` |
| repeat_flag | output | 1 | One-cycle pulse marking a repeat frame |

## Verification
Every result of a frame strobe is registered once. The classification is combinational on the strobe cycle, so `code_out`, `new_code` and `repeat_flag` change on the edge that takes the strobe. A read clears `new_code` on the edge that takes the read. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge that produces the result. It then samples once more to confirm that `repeat_flag` has already dropped. Interval cases use gaps far from `gap_max`, with at least one tick of margin for the free-running prescaler phase, so each verdict is fixed whatever that phase is.

// File: rtl/irr_pkg.sv
package irr_pkg;

    typedef enum logic [1:0] {
        VD_NONE   = 2'd0,
        VD_NEW    = 2'd1,
        VD_REPEAT = 2'd2
    } verdict_e;

    typedef enum logic {
        REF_NONE  = 1'b0,
        REF_VALID = 1'b1
    } ref_state_e;

    typedef enum logic {
        OUT_READ    = 1'b0,
        OUT_PENDING = 1'b1
    } out_state_e;

endpackage

// File: rtl/irr_tick_gen.sv
module irr_tick_gen #(
    parameter int CYC_PER_10US = 500,
    parameter int COARSE_DIV   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_fine,
    output logic tick
);
    localparam int PW = (CYC_PER_10US > 1) ? $clog2(CYC_PER_10US) : 1;
    localparam int DW = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;

    logic          fine_tick;
    logic          coarse_tick;
    logic [DW-1:0] dec_q;

    generate
        if (CYC_PER_10US > 1) begin : g_prescale
            logic [PW-1:0] pre_q;
            assign fine_tick = (pre_q == PW'(CYC_PER_10US - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (fine_tick) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end else begin : g_direct
            assign fine_tick = 1'b1;
        end
    endgenerate

    assign coarse_tick = fine_tick && (dec_q == DW'(COARSE_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else if (coarse_tick) begin
            dec_q <= '0;
        end else if (fine_tick) begin
            dec_q <= dec_q + 1'b1;
        end
    end

    assign tick = tick_fine ? fine_tick : coarse_tick;

endmodule

// File: rtl/irr_gap_counter.sv
module irr_gap_counter #(
    parameter int GAP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic             restart,
    output logic [GAP_W-1:0] gap
);
    localparam logic [GAP_W-1:0] GAP_SAT = '1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (restart || !cnt_en) begin
            gap_q <= '0;
        end else if (tick && (gap_q != GAP_SAT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign gap = gap_q;

endmodule

// File: rtl/irr_classifier.sv
module irr_classifier
    import irr_pkg::*;
#(
    parameter int CODE_W = 32,
    parameter int GAP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [CODE_W-1:0] frame_code,
    input  logic              cmp_en,
    input  logic              time_chk_en,
    input  logic              cnt_en,
    input  logic [GAP_W-1:0]  gap,
    input  logic [GAP_W-1:0]  gap_max,
    output verdict_e          verdict
);
    ref_state_e        state_q, state_d;
    logic [CODE_W-1:0] ref_q;
    logic              same_code;
    logic              in_window;
    logic              is_repeat;

    assign same_code = (frame_code == ref_q);
    assign in_window = !time_chk_en || (cnt_en && (gap < gap_max));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REF_NONE;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            if (verdict == VD_NEW) begin
                ref_q <= frame_code;
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        is_repeat = 1'b0;
        unique case (state_q)
            REF_NONE: begin
                if (frame_valid) begin
                    state_d = REF_VALID;
                end
            end
            REF_VALID: begin
                is_repeat = cmp_en && same_code && in_window;
            end
        endcase
    end

    always_comb begin
        if (!frame_valid) begin
            verdict = VD_NONE;
        end else if (is_repeat) begin
            verdict = VD_REPEAT;
        end else begin
            verdict = VD_NEW;
        end
    end

endmodule

// File: rtl/irr_code_store.sv
module irr_code_store
    import irr_pkg::*;
#(
    parameter int CODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  verdict_e          verdict,
    input  logic [CODE_W-1:0] frame_code,
    input  logic              hold_en,
    input  logic              rd_strobe,
    output logic [CODE_W-1:0] code_out,
    output logic              new_code,
    output logic              repeat_flag
);
    out_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              rpt_q;
    logic              store;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_READ;
            code_q  <= '0;
            rpt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rpt_q   <= (verdict == VD_REPEAT);
            if (store) begin
                code_q <= frame_code;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        store   = 1'b0;
        unique case (state_q)
            OUT_READ: begin
                store = (verdict == VD_NEW);
                if (store) begin
                    state_d = OUT_PENDING;
                end
            end
            OUT_PENDING: begin
                store = (verdict == VD_NEW) && !hold_en;
                if (!store && rd_strobe) begin
                    state_d = OUT_READ;
                end
            end
        endcase
    end

    assign code_out    = code_q;
    assign new_code    = (state_q == OUT_PENDING);
    assign repeat_flag = rpt_q;

endmodule

// File: rtl/ir_repeat_det.sv
module ir_repeat_det
    import irr_pkg::*;
#(
    parameter int CODE_W       = 32,
    parameter int GAP_W        = 12,
    parameter int CYC_PER_10US = 500,
    parameter int COARSE_DIV   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [CODE_W-1:0] frame_code,
    input  logic              cnt_en,
    input  logic              time_chk_en,
    input  logic              cmp_en,
    input  logic              tick_fine,
    input  logic [GAP_W-1:0]  gap_max,
    input  logic              hold_en,
    input  logic              rd_strobe,
    output logic [CODE_W-1:0] code_out,
    output logic              new_code,
    output logic              repeat_flag
);
    logic             tick;
    logic [GAP_W-1:0] gap;
    verdict_e         verdict;

    irr_tick_gen #(
        .CYC_PER_10US (CYC_PER_10US),
        .COARSE_DIV   (COARSE_DIV)
    ) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fine (tick_fine),
        .tick      (tick)
    );

    irr_gap_counter #(
        .GAP_W (GAP_W)
    ) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .tick    (tick),
        .restart (frame_valid),
        .gap     (gap)
    );

    irr_classifier #(
        .CODE_W (CODE_W),
        .GAP_W  (GAP_W)
    ) cls_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_code  (frame_code),
        .cmp_en      (cmp_en),
        .time_chk_en (time_chk_en),
        .cnt_en      (cnt_en),
        .gap         (gap),
        .gap_max     (gap_max),
        .verdict     (verdict)
    );

    irr_code_store #(
        .CODE_W (CODE_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .verdict     (verdict),
        .frame_code  (frame_code),
        .hold_en     (hold_en),
        .rd_strobe   (rd_strobe),
        .code_out    (code_out),
        .new_code    (new_code),
        .repeat_flag (repeat_flag)
    );

endmodule

// File: rtl/irr_checker.sv
module irr_checker #(
    parameter int CODE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid,
    input logic              rd_strobe,
    input logic              cmp_en,
    input logic              hold_en,
    input logic [CODE_W-1:0] code_out,
    input logic              new_code,
    input logic              repeat_flag
);

    AST_RPT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_flag |-> $past(frame_valid)); // R8

    AST_RPT_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_flag |-> ($stable(code_out) && $stable(new_code))); // R8

    AST_NO_RPT_WITHOUT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !cmp_en) |=> !repeat_flag); // R3

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && new_code) |=> $stable(code_out)); // R10

    AST_STORE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out != $past(code_out)) |-> new_code); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_valid) |=> !new_code); // R11

    AST_IDLE_NO_RPT: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !repeat_flag); // R8

endmodule

bind ir_repeat_det irr_checker #(
    .CODE_W (CODE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .rd_strobe   (rd_strobe),
    .cmp_en      (cmp_en),
    .hold_en     (hold_en),
    .code_out    (code_out),
    .new_code    (new_code),
    .repeat_flag (repeat_flag)
);

// File: tb/ir_repeat_det_tb_top.sv
module ir_repeat_det_tb_top;

    localparam int CW = 16;
    localparam int GW = 4;
    localparam int NV = 15;

    typedef struct packed {
        logic [7:0]    wait_c;
        logic [CW-1:0] code;
        logic          cnt;
        logic          chk;
        logic          cmp;
        logic          fine;
        logic          hold;
        logic          rd;
        logic [GW-1:0] gmax;
        logic          exp_rep;
        logic          exp_new;
        logic [CW-1:0] exp_code;
        logic [7:0]    req;
    } vec_t;

    // wait, code, cnt, chk, cmp, fine, hold, rd, gmax, rep, new, code, req
    localparam vec_t VECS [NV] = '{
        '{8'd3,  16'hA1A1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b0, 1'b1, 16'hA1A1, 8'd9},  // R9 first store
        '{8'd3,  16'hA1A1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b1, 1'b1, 16'hA1A1, 8'd3},  // R3 repeat in window
        '{8'd3,  16'hB2B2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b0, 1'b1, 16'hB2B2, 8'd3},  // R3 differs
        '{8'd30, 16'hB2B2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b0, 1'b1, 16'hB2B2, 8'd3},  // R3 too late
        '{8'd3,  16'hB2B2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8,  1'b0, 1'b1, 16'hB2B2, 8'd3},  // R3 compare off
        '{8'd30, 16'hB2B2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b1, 1'b1, 16'hB2B2, 8'd3},  // R3 time check off
        '{8'd3,  16'hB2B2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  1'b0, 1'b1, 16'hB2B2, 8'd6},  // R6 counter off
        '{8'd38, 16'hB2B2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5,  1'b1, 1'b1, 16'hB2B2, 8'd2},  // R2 coarse tick
        '{8'd38, 16'hB2B2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5,  1'b0, 1'b1, 16'hB2B2, 8'd2},  // R2 fine tick
        '{8'd40, 16'hB2B2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 1'b0, 1'b1, 16'hB2B2, 8'd5},  // R5 saturation
        '{8'd3,  16'hC3C3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 16'hB2B2, 8'd10}, // R10 blocked
        '{8'd3,  16'hD4D4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd15, 1'b0, 1'b1, 16'hD4D4, 8'd10}, // R10 read then store
        '{8'd3,  16'hD4D4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd15, 1'b1, 1'b1, 16'hD4D4, 8'd8},  // R8 repeat no store
        '{8'd3,  16'hC3C3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 16'hD4D4, 8'd7},  // R7 blocked new press
        '{8'd3,  16'hC3C3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd15, 1'b1, 1'b1, 16'hD4D4, 8'd7}   // R7 reference moved
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_valid = 1'b0;
    logic [CW-1:0] frame_code = '0;
    logic          cnt_en = 1'b0;
    logic          time_chk_en = 1'b0;
    logic          cmp_en = 1'b0;
    logic          tick_fine = 1'b0;
    logic [GW-1:0] gap_max = '0;
    logic          hold_en = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [CW-1:0] code_out;
    logic          new_code;
    logic          repeat_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ir_repeat_det #(
        .CODE_W       (CW),
        .GAP_W        (GW),
        .CYC_PER_10US (2),
        .COARSE_DIV   (10)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_code  (frame_code),
        .cnt_en      (cnt_en),
        .time_chk_en (time_chk_en),
        .cmp_en      (cmp_en),
        .tick_fine   (tick_fine),
        .gap_max     (gap_max),
        .hold_en     (hold_en),
        .rd_strobe   (rd_strobe),
        .code_out    (code_out),
        .new_code    (new_code),
        .repeat_flag (repeat_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [CW-1:0] c, input logic rd);
        @(negedge clk);
        frame_valid = 1'b1;
        frame_code  = c;
        rd_strobe   = rd;
        @(negedge clk);
        frame_valid = 1'b0;
        rd_strobe   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state right after reset
        check("R1", "code_out", code_out, '0);
        check("R1", "new_code", CW'(new_code), '0);
        check("R1", "repeat_flag", CW'(repeat_flag), '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cnt_en      = VECS[i].cnt;
            time_chk_en = VECS[i].chk;
            cmp_en      = VECS[i].cmp;
            tick_fine   = VECS[i].fine;
            hold_en     = VECS[i].hold;
            gap_max     = VECS[i].gmax;
            if (VECS[i].rd) begin
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
            end
            repeat (VECS[i].wait_c) @(negedge clk);
            send_frame(VECS[i].code, 1'b0);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d repeat_flag", i),
                  CW'(repeat_flag), CW'(VECS[i].exp_rep));
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d new_code", i),
                  CW'(new_code), CW'(VECS[i].exp_new));
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d code_out", i),
                  code_out, VECS[i].exp_code);
            @(negedge clk);
            // R8: pulse is one cycle wide
            check("R8", $sformatf("vec %0d pulse end", i), CW'(repeat_flag), '0);
        end

        // R11: read alone clears the flag
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R11", "read clears new_code", CW'(new_code), '0);
        check("R11", "read keeps code", code_out, 16'hD4D4);

        // R10: hold with flag clear still stores
        hold_en = 1'b1;
        repeat (3) @(negedge clk);
        send_frame(16'hE5E5, 1'b0);
        check("R10", "hold stores after read", code_out, 16'hE5E5);
        check("R10", "hold store sets flag", CW'(new_code), 1);

        // R11: store wins over a read in the same cycle
        hold_en = 1'b0;
        repeat (3) @(negedge clk);
        send_frame(16'h6666, 1'b1);
        check("R11", "store beats read code", code_out, 16'h6666);
        check("R11", "store beats read flag", CW'(new_code), 1);

        // R4: first frame after reset is new even with code 0
        do_reset();
        check("R1", "re-reset code_out", code_out, '0);
        check("R1", "re-reset new_code", CW'(new_code), '0);
        cnt_en = 1'b1; time_chk_en = 1'b0; cmp_en = 1'b1;
        repeat (3) @(negedge clk);
        send_frame(16'h0000, 1'b0);
        check("R4", "first frame not repeat", CW'(repeat_flag), '0);
        check("R4", "first frame stored", CW'(new_code), 1);
        repeat (3) @(negedge clk);
        send_frame(16'h0000, 1'b0);
        check("R3", "second zero frame repeats", CW'(repeat_flag), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule